// File: doc/BRIEF.md
# Two-Channel Compare Output Waveform Unit

This block turns compare-match and BOTTOM events from a timer counter into output waveform bits for two compare channels, A and B. Each channel has a 2-bit output-mode field. What that field means depends on the waveform class that the counter is running: a plain (non-PWM) class, a fast PWM class, or an up/down PWM class. The block supports set or clear on a match, toggle on a match, set or clear at BOTTOM, and set or clear that depends on the count direction. It also handles the case where a channel's compare value equals TOP.

For each channel the block also produces an override request. A nonzero output mode asks to take the pin from its normal function. The waveform reaches the pin only when the channel's direction-enable bit is also set.

The block does not count and does not raise flags. The counter supplies one-cycle match and BOTTOM pulses, the count direction, and a flag per channel that tells whether the compare value equals TOP.

Top module: `cmpout_unit`

## Requirements
- R1: While `rst_n` is low, and on the first sample after reset with all inputs 0, `wave_a`/`wave_b` read 0 and `ovr_a`/`ovr_b`/`pin_oe_a`/`pin_oe_b` read 0.
- R2: Output mode 2'b00 keeps the override low and leaves the channel's wave bit unchanged, in every waveform class.
- R3: In the plain class (`wave_class` 2'b00, and 2'b11, which behaves the same way), a match does the following: mode 2'b01 toggles the wave bit, 2'b10 clears it and 2'b11 sets it. BOTTOM, the count direction and the equals-TOP flag have no effect.
- R4: In the fast class (`wave_class` 2'b01), mode 2'b10 clears the bit on a match and sets it on BOTTOM, and mode 2'b11 sets it on a match and clears it on BOTTOM. When a match and BOTTOM arrive in the same cycle, the match wins.
- R5: In the fast class with mode bit 1 set, a match that arrives while the equals-TOP flag is high is ignored, and only the BOTTOM action applies.
- R6: In the up/down class (`wave_class` 2'b10), mode 2'b10 clears the bit on a match while `count_up` is 1 and sets it on a match while `count_up` is 0. Mode 2'b11 does the opposite. BOTTOM has no effect.
- R7: In the up/down class, a match that arrives while the equals-TOP flag is high is treated as an up-count match, whatever `count_up` says.
- R8: In either PWM class, mode 2'b01 with `top_sel` equal to 0 disconnects the channel: the override stays low and the bit holds.
- R9: In either PWM class, mode 2'b01 with `top_sel` equal to 1 toggles channel A on a match and asserts its override. For channel B this setting is reserved: B holds its bit and keeps its override low.
- R10: `pin_oe_x` is high exactly when `ovr_x` is high and `dir_en_x` is 1.
- R11: Wave bits are registered. They change on the rising clock edge at which the qualifying match or BOTTOM pulse is sampled, and `ovr`/`pin_oe` follow the current inputs combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wave_class | input | 2 | 00 plain, 01 fast PWM, 10 up/down PWM, 11 plain |
| top_sel | input | 1 | Highest mode-select bit; enables the mode-01 toggle in PWM classes |
| bottom_pulse | input | 1 | One-cycle pulse when the counter reaches BOTTOM |
| count_up | input | 1 | 1 while the counter counts up |
| mode_a | input | 2 | Output-mode field for channel A |
| mode_b | input | 2 | Output-mode field for channel B |
| match_a | input | 1 | Compare-match pulse for channel A |
| match_b | input | 1 | Compare-match pulse for channel B |
| eq_top_a | input | 1 | Channel A compare value equals TOP |
| eq_top_b | input | 1 | Channel B compare value equals TOP |
| dir_en_a | input | 1 | Direction enable for channel A's pin |
| dir_en_b | input | 1 | Direction enable for channel B's pin |
| wave_a | output | 1 | Channel A waveform bit |
| wave_b | output | 1 | Channel B waveform bit |
| ovr_a | output | 1 | Channel A pin-override request |
| ovr_b | output | 1 | Channel B pin-override request |
| pin_oe_a | output | 1 | Channel A waveform drives the pin |
| pin_oe_b | output | 1 | Channel B waveform drives the pin |

## Verification
The assertions assume that the counter produces match and BOTTOM as single-cycle pulses. They also assume that the equals-TOP and direction inputs are valid in every cycle, and they make no assumption about how these events are spaced. Within each cycle the stimulus draws every input independently. This includes a match and BOTTOM in the same cycle and an equals-TOP match in every class, so the priority rules are always exercised. The waveform class and the modes change freely from one cycle to the next, because the block keeps no state other than the wave bits.

// File: rtl/cmpout_pkg.sv
package cmpout_pkg;

  typedef enum logic [1:0] {
    CLS_PLAIN = 2'b00,
    CLS_FAST  = 2'b01,
    CLS_UPDN  = 2'b10,
    CLS_ALT   = 2'b11
  } wave_class_e;

  typedef enum logic [1:0] {
    ACT_HOLD = 2'b00,
    ACT_CLR  = 2'b01,
    ACT_SET  = 2'b10,
    ACT_TGL  = 2'b11
  } act_e;

  localparam int MODE_W = 2;

  function automatic logic is_pwm(input logic [1:0] cls);
    return (cls == CLS_FAST) || (cls == CLS_UPDN);
  endfunction

  // Action chosen for one channel in one cycle.
  function automatic act_e pick_action(
    input logic [1:0] cls,
    input logic [MODE_W-1:0] om,
    input logic tgl_ok,
    input logic top_sel,
    input logic match,
    input logic bottom,
    input logic up,
    input logic eq_top
  );
    logic eff_up;
    if (om == 2'b00) return ACT_HOLD;
    if (!is_pwm(cls)) begin
      if (!match) return ACT_HOLD;
      case (om)
        2'b01:   return ACT_TGL;
        2'b10:   return ACT_CLR;
        default: return ACT_SET;
      endcase
    end
    if (om == 2'b01) begin
      if (top_sel && tgl_ok && match) return ACT_TGL;
      return ACT_HOLD;
    end
    if (cls == CLS_FAST) begin
      if (match && !eq_top) return om[0] ? ACT_SET : ACT_CLR;
      if (bottom) return om[0] ? ACT_CLR : ACT_SET;
      return ACT_HOLD;
    end
    if (!match) return ACT_HOLD;
    eff_up = up | eq_top;
    return (eff_up ^ om[0]) ? ACT_CLR : ACT_SET;
  endfunction

  function automatic logic wants_pin(
    input logic [1:0] cls,
    input logic [MODE_W-1:0] om,
    input logic tgl_ok,
    input logic top_sel
  );
    if (om == 2'b00) return 1'b0;
    if (is_pwm(cls) && om == 2'b01) return top_sel & tgl_ok;
    return 1'b1;
  endfunction

  function automatic logic apply_action(input act_e a, input logic cur);
    case (a)
      ACT_CLR: return 1'b0;
      ACT_SET: return 1'b1;
      ACT_TGL: return ~cur;
      default: return cur;
    endcase
  endfunction

endpackage

// File: rtl/cmpout_decode.sv
module cmpout_decode
  import cmpout_pkg::*;
#(
  parameter bit TOGGLE_OK = 1'b1
) (
  input  logic [1:0]        cls,
  input  logic [MODE_W-1:0] om,
  input  logic              top_sel,
  input  logic              match,
  input  logic              bottom,
  input  logic              up,
  input  logic              eq_top,
  output act_e              act,
  output logic              ovr
);

  always_comb begin
    act = pick_action(cls, om, TOGGLE_OK, top_sel, match, bottom, up, eq_top);
    ovr = wants_pin(cls, om, TOGGLE_OK, top_sel);
  end

endmodule

// File: rtl/cmpout_wave_reg.sv
module cmpout_wave_reg
  import cmpout_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  act_e act,
  output logic wave
);

  always_ff @(posedge clk) begin
    if (!rst_n) wave <= 1'b0;
    else        wave <= apply_action(act, wave);
  end

  // R11
  set_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act == ACT_SET |=> wave);
  // R11
  clr_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act == ACT_CLR |=> !wave);
  // R11
  tgl_flips_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act == ACT_TGL |=> wave != $past(wave));
  // R11
  hold_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act == ACT_HOLD |=> $stable(wave));

endmodule

// File: rtl/cmpout_channel.sv
module cmpout_channel
  import cmpout_pkg::*;
#(
  parameter bit TOGGLE_OK = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cls,
  input  logic              top_sel,
  input  logic [MODE_W-1:0] om,
  input  logic              match,
  input  logic              bottom,
  input  logic              up,
  input  logic              eq_top,
  input  logic              dir_en,
  output logic              wave,
  output logic              ovr,
  output logic              pin_oe
);

  act_e act_w;
  logic ovr_w;

  cmpout_decode #(.TOGGLE_OK(TOGGLE_OK)) u_dec (
    .cls(cls), .om(om), .top_sel(top_sel), .match(match),
    .bottom(bottom), .up(up), .eq_top(eq_top), .act(act_w), .ovr(ovr_w)
  );

  cmpout_wave_reg u_reg (
    .clk(clk), .rst_n(rst_n), .act(act_w), .wave(wave)
  );

  assign ovr    = ovr_w;
  assign pin_oe = ovr_w & dir_en;

  // R2
  off_no_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    om == 2'b00 |-> !ovr);
  // R2
  off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    om == 2'b00 |=> $stable(wave));
  // R5
  top_match_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cls == CLS_FAST && om[1] && match && eq_top && !bottom) |=> $stable(wave));
  // R6
  updn_no_bottom_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cls == CLS_UPDN && !match && bottom) |=> $stable(wave));
  // R8
  pwm_01_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_pwm(cls) && om == 2'b01 && !top_sel) |-> !ovr);
  // R10
  pin_needs_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pin_oe |-> (ovr && dir_en));

  generate
    if (!TOGGLE_OK) begin : g_reserved
      // R9
      reserved_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_pwm(cls) && om == 2'b01) |=> $stable(wave));
    end
  endgenerate

endmodule

// File: rtl/cmpout_unit.sv
module cmpout_unit
  import cmpout_pkg::*;
#(
  parameter logic [1:0] TOGGLE_MASK = 2'b01
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] wave_class,
  input  logic       top_sel,
  input  logic       bottom_pulse,
  input  logic       count_up,
  input  logic [1:0] mode_a,
  input  logic [1:0] mode_b,
  input  logic       match_a,
  input  logic       match_b,
  input  logic       eq_top_a,
  input  logic       eq_top_b,
  input  logic       dir_en_a,
  input  logic       dir_en_b,
  output logic       wave_a,
  output logic       wave_b,
  output logic       ovr_a,
  output logic       ovr_b,
  output logic       pin_oe_a,
  output logic       pin_oe_b
);

  localparam int NUM_CH = 2;

  logic [NUM_CH-1:0][MODE_W-1:0] om_v;
  logic [NUM_CH-1:0] match_v, eq_v, dir_v, wave_v, ovr_v, oe_v;

  assign om_v    = {mode_b, mode_a};
  assign match_v = {match_b, match_a};
  assign eq_v    = {eq_top_b, eq_top_a};
  assign dir_v   = {dir_en_b, dir_en_a};

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      cmpout_channel #(.TOGGLE_OK(TOGGLE_MASK[c])) u_ch (
        .clk(clk), .rst_n(rst_n), .cls(wave_class), .top_sel(top_sel),
        .om(om_v[c]), .match(match_v[c]), .bottom(bottom_pulse),
        .up(count_up), .eq_top(eq_v[c]), .dir_en(dir_v[c]),
        .wave(wave_v[c]), .ovr(ovr_v[c]), .pin_oe(oe_v[c])
      );
    end
  endgenerate

  assign wave_a   = wave_v[0];
  assign wave_b   = wave_v[1];
  assign ovr_a    = ovr_v[0];
  assign ovr_b    = ovr_v[1];
  assign pin_oe_a = oe_v[0];
  assign pin_oe_b = oe_v[1];

  // R1
  reset_low_chk: assert property (@(posedge clk)
    !rst_n |=> (!wave_a && !wave_b));

endmodule

// File: tb/test_cmpout_unit.sv
`timescale 1ns/1ps
module test_cmpout_unit;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] cls = 2'b00, ma = 2'b00, mb = 2'b00;
  logic tsel = 1'b0, bot = 1'b0, up = 1'b0;
  logic mta = 1'b0, mtb = 1'b0, eqa = 1'b0, eqb = 1'b0, dea = 1'b0, deb = 1'b0;
  logic wa, wb, oa, ob, pa, pb;

  int checks = 0, fails = 0;
  logic exp_a = 1'b0, exp_b = 1'b0;
  string tag_a = "R1", tag_b = "R1";
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cmpout_unit i_cmpout_unit (
    .clk(clk), .rst_n(rst_n), .wave_class(cls), .top_sel(tsel),
    .bottom_pulse(bot), .count_up(up), .mode_a(ma), .mode_b(mb),
    .match_a(mta), .match_b(mtb), .eq_top_a(eqa), .eq_top_b(eqb),
    .dir_en_a(dea), .dir_en_b(deb), .wave_a(wa), .wave_b(wb),
    .ovr_a(oa), .ovr_b(ob), .pin_oe_a(pa), .pin_oe_b(pb)
  );

  function automatic logic model_next(input logic [1:0] c, input logic [1:0] om,
      input bit is_a, input logic ts, input logic m, input logic b,
      input logic u, input logic eq, input logic cur);
    logic p;
    p = c[0] ^ c[1];
    if (om == 2'b00) return cur;
    if (!p) return m ? ((om == 2'b01) ? ~cur : om[0]) : cur;
    if (om == 2'b01) return (ts && is_a && m) ? ~cur : cur;
    if (c == 2'b01) begin
      if (m && !eq) return om[0];
      if (b) return ~om[0];
      return cur;
    end
    if (!m) return cur;
    return (u || eq) ? om[0] : ~om[0];
  endfunction

  function automatic logic model_ovr(input logic [1:0] c, input logic [1:0] om,
      input bit is_a, input logic ts);
    if (om == 2'b00) return 1'b0;
    if ((c[0] ^ c[1]) && om == 2'b01) return ts && is_a;
    return 1'b1;
  endfunction

  function automatic string req_of(input logic [1:0] c, input logic [1:0] om,
      input logic ts, input logic m, input logic eq);
    if (om == 2'b00) return "R2";
    if (!(c[0] ^ c[1])) return "R3";
    if (om == 2'b01) return ts ? "R9" : "R8";
    if (c == 2'b01) return (eq && m) ? "R5" : "R4";
    return eq ? "R7" : "R6";
  endfunction

  task automatic check(input string req, input string what,
                       input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic step(input logic [1:0] c, input logic ts, input logic b,
      input logic u, input logic [1:0] oma, input logic [1:0] omb,
      input logic m_a, input logic m_b, input logic e_a, input logic e_b,
      input logic d_a, input logic d_b);
    @(negedge clk);
    check({tag_a, "/R11"}, "wave_a", wa, exp_a);
    check({tag_b, "/R11"}, "wave_b", wb, exp_b);
    cls = c; tsel = ts; bot = b; up = u; ma = oma; mb = omb;
    mta = m_a; mtb = m_b; eqa = e_a; eqb = e_b; dea = d_a; deb = d_b;
    #1;
    check(req_of(c, oma, ts, m_a, e_a), "ovr_a", oa, model_ovr(c, oma, 1'b1, ts));
    check(req_of(c, omb, ts, m_b, e_b), "ovr_b", ob, model_ovr(c, omb, 1'b0, ts));
    check("R10", "pin_oe_a", pa, model_ovr(c, oma, 1'b1, ts) & d_a);
    check("R10", "pin_oe_b", pb, model_ovr(c, omb, 1'b0, ts) & d_b);
    tag_a = req_of(c, oma, ts, m_a, e_a);
    tag_b = req_of(c, omb, ts, m_b, e_b);
    exp_a = model_next(c, oma, 1'b1, ts, m_a, b, u, e_a, exp_a);
    exp_b = model_next(c, omb, 1'b0, ts, m_b, b, u, e_b, exp_b);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", "wave_a in reset", wa, 1'b0);
    check("R1", "wave_b in reset", wb, 1'b0);
    check("R1", "ovr_a in reset", oa, 1'b0);
    check("R1", "pin_oe_b in reset", pb, 1'b0);
    rst_n = 1'b1;
    // R3: set, toggle and clear on a match; BOTTOM ignored
    step(2'b00, 0, 1, 0, 2'b11, 2'b01, 1, 1, 0, 0, 1, 1);
    step(2'b00, 0, 1, 1, 2'b01, 2'b10, 1, 1, 1, 1, 1, 0);
    step(2'b11, 0, 0, 0, 2'b11, 2'b11, 1, 0, 0, 0, 0, 0);
    // R4: BOTTOM sets, then a match clears; then a match and BOTTOM together
    step(2'b01, 0, 1, 1, 2'b10, 2'b11, 0, 0, 0, 0, 1, 1);
    step(2'b01, 0, 0, 1, 2'b10, 2'b11, 1, 1, 0, 0, 1, 1);
    step(2'b01, 0, 1, 1, 2'b10, 2'b11, 1, 1, 0, 0, 1, 1);
    // R5: an equals-TOP match is ignored, only BOTTOM acts
    step(2'b01, 0, 1, 1, 2'b10, 2'b10, 0, 0, 1, 1, 1, 1);
    step(2'b01, 0, 0, 1, 2'b10, 2'b10, 1, 1, 1, 1, 1, 1);
    // R6 / R7: direction-dependent actions, equals-TOP as an up-count match
    step(2'b10, 0, 0, 0, 2'b10, 2'b11, 1, 1, 0, 0, 1, 1);
    step(2'b10, 0, 1, 1, 2'b10, 2'b11, 1, 1, 0, 0, 1, 1);
    step(2'b10, 0, 0, 0, 2'b10, 2'b11, 1, 1, 1, 1, 1, 1);
    // R8 / R9: mode 01 in the PWM classes
    step(2'b01, 0, 0, 0, 2'b01, 2'b01, 1, 1, 0, 0, 1, 1);
    step(2'b10, 1, 0, 0, 2'b01, 2'b01, 1, 1, 0, 0, 1, 1);
    step(2'b01, 1, 0, 0, 2'b01, 2'b01, 1, 1, 0, 0, 0, 1);
    // R2: output mode 00 holds
    step(2'b00, 0, 1, 0, 2'b00, 2'b00, 1, 1, 0, 0, 1, 1);
    for (int i = 0; i < 3000; i++) begin
      step(2'($urandom), 1'($urandom), ($urandom % 5) == 0, 1'($urandom),
           2'($urandom), 2'($urandom), ($urandom % 3) == 0, ($urandom % 3) == 0,
           ($urandom % 6) == 0, ($urandom % 6) == 0, 1'($urandom), 1'($urandom));
    end
    step(2'b00, 0, 0, 0, 2'b00, 2'b00, 0, 0, 0, 0, 0, 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule